// File: doc/BRIEF.md
# Up/Down Wiper Interface Sequencer

This block sits on the host side of a digitally stepped potentiometer that is controlled by three wires: an active-low select, a direction level and an active-low step strobe whose falling edge moves the wiper one tap. A client hands the block a command holding a target tap, a keep flag and a calibrate flag. The block remembers the tap it believes the wiper is on. From the target and that tap it works out the direction and the number of steps. It then plays out a select, step and release waveform in which every setup, pulse width and hold-off is a parameter counted in system clock cycles.

The level of the step strobe at the moment select is released decides what happens to the position. If the strobe is high, the device writes its position to nonvolatile storage. If the strobe is low, the change stays volatile. After every release the select line is held high for a programmable hold-off before the block reports completion and takes the next command. A calibrate command walks the wiper down by the full tap count. The wiper saturates at the bottom, so afterwards the tracked tap is known to be zero no matter where the wiper started.

Top module: `potdrv_host`

## Requirements
- R1: After reset, sel_n=1, step_n=1, busy=0, done=0, cmd_ready=1 and pos_out=INIT_POS.
- R2: cmd_ready is 1 only while the block is idle. A command is taken on a clock edge where cmd_valid and cmd_ready are both 1. A command held valid during a transaction or its hold-off is not taken until the block has returned to idle.
- R3: A normal command produces exactly |cmd_target - pos_out| falling edges on step_n. dir_up is 1 (up) when the target is above the tracked tap and 0 (down) when it is below. dir_up changes only on the edge that takes a command with a nonzero step count, and stays constant while sel_n is 0.
- R4: sel_n stays low for exactly max(T_CS_SETUP, T_DIR_SETUP) cycles before the first fall of step_n, with step_n held high during that time.
- R5: Each step holds step_n low for T_LOW cycles. Between consecutive steps, step_n is high for T_HIGH cycles.
- R6: With cmd_store=1, step_n is high for T_HIGH cycles after the last step and then for T_END more cycles with sel_n low. sel_n then rises while step_n is 1.
- R7: With cmd_store=0, step_n stays low for T_LOW+T_END cycles after the last fall. sel_n then rises while step_n is 0, and step_n returns to 1 one cycle later.
- R8: After each release, sel_n stays high for T_DESEL+1 cycles before done.
- R9: If the target equals the tracked tap and cmd_store=1, the block selects, waits the setup time and T_END, and releases with step_n high, with no step. If the target equals the tracked tap and cmd_store=0, the pins do not move and done follows on the next cycle.
- R10: A command with cmd_calib=1 ignores cmd_target and issues 2**POS_W down steps. pos_out becomes 0.
- R11: pos_out takes the new tracked tap (the target, or 0 for calibrate) on the edge that takes the command, and changes at no other time.
- R12: done is a single-cycle pulse during which busy is 0. cmd_ready returns to 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_target | input | POS_W | Requested tap |
| cmd_store | input | 1 | 1: keep the position in nonvolatile storage; 0: volatile change |
| cmd_calib | input | 1 | 1: full-range down walk to tap 0 |
| sel_n | output | 1 | Active-low device select |
| dir_up | output | 1 | Step direction, 1 = up |
| step_n | output | 1 | Active-low step strobe; each falling edge moves one tap |
| busy | output | 1 | Transaction or hold-off in progress |
| done | output | 1 | One-cycle completion pulse |
| pos_out | output | POS_W | Tracked wiper tap |

## Verification
The assertions check the timing rules on every cycle using saturating run-length counters:
- the select-to-first-step setup;
- the minimum low width of the strobe;
- that the strobe level does not change on the release edge;
- the select-high hold-off;
- that the direction stays constant while selected;
- the ready/busy/done exclusivity;
- that the tracked tap changes only when a command is taken.

Other behaviour can only be shown by the bench's scenarios. These are the exact step count, whether a command results in a store or a volatile change, the zero-step cases, the calibrate walk from an unknown wiper tap, and the refusal of a command held during hold-off. The bench shows them by comparing every cycle against a queued waveform model and against a small behavioural model of the device.

// File: rtl/potdrv_pkg.sv
package potdrv_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_LOW,
      PH_HIGH,
      PH_TAIL,
      PH_RELEASE,
      PH_HOLD,
      PH_FINISH
   } phase_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/potdrv_timer.sv
module potdrv_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - CNT_W'(1);
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/potdrv_planner.sv
module potdrv_planner #(
   parameter int POS_W  = 5,
   parameter bit CAL_EN = 1'b1,
   localparam int STEP_W = POS_W + 1
) (
   input  logic [POS_W-1:0]  target,
   input  logic [POS_W-1:0]  cur_pos,
   input  logic              calib,
   output logic [STEP_W-1:0] steps,
   output logic              up,
   output logic [POS_W-1:0]  next_pos
);

   localparam logic [STEP_W-1:0] FULL_WALK = STEP_W'(2 ** POS_W);

   logic calib_eff;

   generate
      if (CAL_EN) begin : g_cal
         assign calib_eff = calib;
      end else begin : g_nocal
         assign calib_eff = 1'b0;
      end
   endgenerate

   always_comb begin
      if (calib_eff) begin
         steps    = FULL_WALK;
         up       = 1'b0;
         next_pos = '0;
      end else if (target >= cur_pos) begin
         steps    = {1'b0, target - cur_pos};
         up       = 1'b1;
         next_pos = target;
      end else begin
         steps    = {1'b0, cur_pos - target};
         up       = 1'b0;
         next_pos = target;
      end
   end

endmodule

// File: rtl/potdrv_seq.sv
module potdrv_seq
   import potdrv_pkg::*;
#(
   parameter int POS_W   = 5,
   parameter int CNT_W   = 8,
   parameter int L_SU    = 4,
   parameter int T_LOW   = 2,
   parameter int T_HIGH  = 2,
   parameter int T_END   = 2,
   parameter int T_DESEL = 4,
   localparam int STEP_W = POS_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [STEP_W-1:0] start_steps,
   input  logic              start_store,
   input  logic              tmr_expired,
   output logic              tmr_load,
   output logic [CNT_W-1:0]  tmr_val,
   output logic              idle,
   output logic              sel_n,
   output logic              step_n,
   output logic              busy,
   output logic              done
);

   localparam logic [CNT_W-1:0] V_SU    = CNT_W'(L_SU - 1);
   localparam logic [CNT_W-1:0] V_LOW   = CNT_W'(T_LOW - 1);
   localparam logic [CNT_W-1:0] V_HIGH  = CNT_W'(T_HIGH - 1);
   localparam logic [CNT_W-1:0] V_END   = CNT_W'(T_END - 1);
   localparam logic [CNT_W-1:0] V_DESEL = CNT_W'(T_DESEL - 1);
   localparam int               MON_W   = CNT_W + 1;

   phase_e            phase_q, phase_d;
   logic [STEP_W-1:0] left_q, left_d;
   logic              store_q;

   always_comb begin
      phase_d  = phase_q;
      left_d   = left_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (phase_q)
         PH_IDLE: begin
            if (start) begin
               tmr_load = 1'b1;
               left_d   = start_steps;
               if ((start_steps == '0) && !start_store) begin
                  phase_d = PH_FINISH;
               end else begin
                  phase_d = PH_SETUP;
                  tmr_val = V_SU;
               end
            end
         end
         PH_SETUP: begin
            if (tmr_expired) begin
               tmr_load = 1'b1;
               if (left_q == '0) begin
                  phase_d = PH_TAIL;
                  tmr_val = V_END;
               end else begin
                  phase_d = PH_LOW;
                  tmr_val = V_LOW;
               end
            end
         end
         PH_LOW: begin
            if (tmr_expired) begin
               tmr_load = 1'b1;
               left_d   = left_q - STEP_W'(1);
               if ((left_d != '0) || store_q) begin
                  phase_d = PH_HIGH;
                  tmr_val = V_HIGH;
               end else begin
                  phase_d = PH_TAIL;
                  tmr_val = V_END;
               end
            end
         end
         PH_HIGH: begin
            if (tmr_expired) begin
               tmr_load = 1'b1;
               if (left_q != '0) begin
                  phase_d = PH_LOW;
                  tmr_val = V_LOW;
               end else begin
                  phase_d = PH_TAIL;
                  tmr_val = V_END;
               end
            end
         end
         PH_TAIL: begin
            if (tmr_expired) begin
               tmr_load = 1'b1;
               phase_d  = PH_RELEASE;
            end
         end
         PH_RELEASE: begin
            if (tmr_expired) begin
               tmr_load = 1'b1;
               phase_d  = PH_HOLD;
               tmr_val  = V_DESEL;
            end
         end
         PH_HOLD: begin
            if (tmr_expired) begin
               tmr_load = 1'b1;
               phase_d  = PH_FINISH;
            end
         end
         PH_FINISH: begin
            phase_d = PH_IDLE;
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         left_q  <= '0;
         store_q <= 1'b0;
      end else begin
         phase_q <= phase_d;
         left_q  <= left_d;
         if ((phase_q == PH_IDLE) && start)
            store_q <= start_store;
      end
   end

   // Pin decode: the strobe level in the tail and release phases picks keep or volatile
   always_comb begin
      sel_n  = 1'b0;
      step_n = 1'b1;
      unique case (phase_q)
         PH_IDLE, PH_HOLD, PH_FINISH: sel_n = 1'b1;
         PH_RELEASE: begin
            sel_n  = 1'b1;
            step_n = store_q;
         end
         PH_LOW:  step_n = 1'b0;
         PH_TAIL: step_n = store_q;
         default: ;
      endcase
   end

   assign idle = (phase_q == PH_IDLE);
   assign busy = (phase_q != PH_IDLE) && (phase_q != PH_FINISH);
   assign done = (phase_q == PH_FINISH);

   // Run-length monitors for the timing assertions
   logic [MON_W-1:0] sel_lo_run, sel_hi_run, stp_lo_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_lo_run <= '0;
         sel_hi_run <= '1;
         stp_lo_run <= '0;
      end else begin
         sel_lo_run <= sel_n ? '0 : ((sel_lo_run == '1) ? sel_lo_run : sel_lo_run + MON_W'(1));
         sel_hi_run <= !sel_n ? '0 : ((sel_hi_run == '1) ? sel_hi_run : sel_hi_run + MON_W'(1));
         stp_lo_run <= step_n ? '0 : ((stp_lo_run == '1) ? stp_lo_run : stp_lo_run + MON_W'(1));
      end
   end

   a_r4_select_setup: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(step_n) |-> (!sel_n && (sel_lo_run >= MON_W'(L_SU))));

   a_r5_low_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(step_n) |-> (stp_lo_run >= MON_W'(T_LOW)));

   a_r6_level_held_at_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel_n) |-> $stable(step_n));

   a_r8_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sel_n) |-> (sel_hi_run >= MON_W'(T_DESEL + 1)));

   a_r2_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> (!busy && !done && sel_n));

   a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && idle));

endmodule

// File: rtl/potdrv_host.sv
module potdrv_host
   import potdrv_pkg::*;
#(
   parameter int POS_W       = 5,
   parameter bit CAL_EN      = 1'b1,
   parameter int INIT_POS    = 0,
   parameter int T_CS_SETUP  = 20,
   parameter int T_DIR_SETUP = 580,
   parameter int T_LOW       = 200,
   parameter int T_HIGH      = 200,
   parameter int T_END       = 200,
   parameter int T_DESEL     = 4_000_000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic [POS_W-1:0] cmd_target,
   input  logic             cmd_store,
   input  logic             cmd_calib,
   output logic             sel_n,
   output logic             dir_up,
   output logic             step_n,
   output logic             busy,
   output logic             done,
   output logic [POS_W-1:0] pos_out
);

   localparam int L_SU   = int'(max2(T_CS_SETUP, T_DIR_SETUP));
   localparam int T_MAX  = int'(max2(max2(L_SU, T_LOW), max2(max2(T_HIGH, T_END), T_DESEL)));
   localparam int CNT_W  = $clog2(T_MAX + 1);
   localparam int STEP_W = POS_W + 1;

   generate
      if (POS_W < 1 || POS_W > 8) begin : g_bad_pos_w
         $error("POS_W must lie in 1..8");
      end
      if (INIT_POS < 0 || INIT_POS >= (2 ** POS_W)) begin : g_bad_init
         $error("INIT_POS outside the tap range");
      end
      if (T_CS_SETUP < 1 || T_DIR_SETUP < 1 || T_LOW < 1 || T_HIGH < 1) begin : g_bad_step_t
         $error("setup and strobe widths must be at least one cycle");
      end
      if (T_END < 1 || T_DESEL < 1) begin : g_bad_end_t
         $error("tail and hold-off must be at least one cycle");
      end
   endgenerate

   logic              take;
   logic [STEP_W-1:0] plan_steps;
   logic              plan_up;
   logic [POS_W-1:0]  plan_pos;
   logic              tmr_load, tmr_expired;
   logic [CNT_W-1:0]  tmr_val;
   logic              seq_idle;
   logic [POS_W-1:0]  pos_q;
   logic              dir_q;

   assign cmd_ready = seq_idle;
   assign take      = cmd_valid && seq_idle;

   potdrv_planner #(
      .POS_W  (POS_W),
      .CAL_EN (CAL_EN)
   ) u_plan (
      .target   (cmd_target),
      .cur_pos  (pos_q),
      .calib    (cmd_calib),
      .steps    (plan_steps),
      .up       (plan_up),
      .next_pos (plan_pos)
   );

   potdrv_timer #(
      .CNT_W (CNT_W)
   ) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   potdrv_seq #(
      .POS_W   (POS_W),
      .CNT_W   (CNT_W),
      .L_SU    (L_SU),
      .T_LOW   (T_LOW),
      .T_HIGH  (T_HIGH),
      .T_END   (T_END),
      .T_DESEL (T_DESEL)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (take),
      .start_steps (plan_steps),
      .start_store (cmd_store),
      .tmr_expired (tmr_expired),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .idle        (seq_idle),
      .sel_n       (sel_n),
      .step_n      (step_n),
      .busy        (busy),
      .done        (done)
   );

   // Tracked tap and direction move only when a command is taken
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= POS_W'(INIT_POS);
         dir_q <= 1'b0;
      end else if (take) begin
         pos_q <= plan_pos;
         if (plan_steps != '0)
            dir_q <= plan_up;
      end
   end

   assign pos_out = pos_q;
   assign dir_up  = dir_q;

   a_r3_dir_steady_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n && $past(!sel_n)) |-> $stable(dir_up));

   a_r11_pos_moves_on_take: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && cmd_ready) |=> $stable(pos_out));

endmodule

// File: tb/potdrv_host_bench.sv
`timescale 1ns/1ps
module potdrv_host_bench;

   localparam int POS_W   = 5;
   localparam int T_CSU   = 2;
   localparam int T_DSU   = 5;
   localparam int L_SU    = (T_CSU > T_DSU) ? T_CSU : T_DSU;
   localparam int T_LOW   = 3;
   localparam int T_HIGH  = 2;
   localparam int T_END   = 4;
   localparam int T_DESEL = 10;
   localparam int TOP     = (1 << POS_W) - 1;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic             rst_n = 1'b0;
   logic             cmd_valid = 1'b0;
   logic [POS_W-1:0] cmd_target = '0;
   logic             cmd_store = 1'b0;
   logic             cmd_calib = 1'b0;
   logic             cmd_ready, sel_n, dir_up, step_n, busy, done;
   logic [POS_W-1:0] pos_out;

   potdrv_host #(
      .POS_W (POS_W), .CAL_EN (1'b1), .INIT_POS (0),
      .T_CS_SETUP (T_CSU), .T_DIR_SETUP (T_DSU), .T_LOW (T_LOW),
      .T_HIGH (T_HIGH), .T_END (T_END), .T_DESEL (T_DESEL)
   ) u_potdrv_host (
      .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
      .cmd_target (cmd_target), .cmd_store (cmd_store), .cmd_calib (cmd_calib),
      .sel_n (sel_n), .dir_up (dir_up), .step_n (step_n), .busy (busy),
      .done (done), .pos_out (pos_out)
   );

   typedef struct {
      logic sel;
      logic stp;
      logic bsy;
      logic dn;
      int   req;
   } exp_t;

   exp_t q[$];
   int   n_run = 0, n_fail = 0;
   int   exp_pos = 0;
   logic exp_dir = 1'b0;
   bit   last_idle = 1'b1;
   logic prev_step = 1'b1;
   int   pulses = 0, exp_pulses = 0, txn_req = 0;
   bit   txn_open = 1'b0, txn_store = 1'b0, finished = 1'b0;

   // Behavioural device: saturating tap counter and nonvolatile copy
   int wiper = 17;
   int nv = -1;
   always @(negedge step_n) begin
      if (rst_n && !sel_n) begin
         if (dir_up) begin
            if (wiper < TOP) wiper++;
         end else if (wiper > 0) begin
            wiper--;
         end
      end
   end
   always @(posedge sel_n) if (rst_n && step_n) nv = wiper;

   task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic cyc();
      exp_t e;
      bit   had;
      @(negedge clk);
      had = (q.size() > 0);
      if (had) e = q.pop_front();
      else e = '{sel: 1'b1, stp: 1'b1, bsy: 1'b0, dn: 1'b0, req: 2};
      chk(e.req, "sel_n", 32'(sel_n), 32'(e.sel));
      chk(e.req, "step_n", 32'(step_n), 32'(e.stp));
      chk(e.req, "busy", 32'(busy), 32'(e.bsy));
      chk(e.req, "done", 32'(done), 32'(e.dn));
      chk(2, "cmd_ready", 32'(cmd_ready), 32'(!had));
      chk(3, "dir_up", 32'(dir_up), 32'(exp_dir));
      chk(11, "pos_out", 32'(pos_out), 32'(exp_pos));
      if (!sel_n && prev_step && !step_n) pulses++;
      prev_step = step_n;
      last_idle = !had;
      if (had && (q.size() == 0) && txn_open) begin
         txn_open = 1'b0;
         chk(txn_req, "step count", 32'(pulses), 32'(exp_pulses));
         chk(txn_req, "device tap", 32'(wiper), 32'(exp_pos));
         if (txn_store) chk(6, "stored tap", 32'(nv), 32'(exp_pos));
      end
   endtask

   task automatic push(input logic s, input logic p, input logic b, input logic d, input int req, input int n);
      for (int k = 0; k < n; k++) q.push_back('{sel: s, stp: p, bsy: b, dn: d, req: req});
   endtask

   // Holds cmd_valid until the block is idle, then queues the expected waveform
   task automatic send(input int tgt, input bit store, input bit calib, input int req);
      int n, tr;
      cmd_target = POS_W'(tgt);
      cmd_store  = store;
      cmd_calib  = calib;
      cmd_valid  = 1'b1;
      while (!last_idle) cyc();
      if (calib) begin
         n = 1 << POS_W;
         exp_dir = 1'b0;
         exp_pos = 0;
      end else begin
         n = (tgt > exp_pos) ? tgt - exp_pos : exp_pos - tgt;
         if (n > 0) exp_dir = (tgt > exp_pos);
         exp_pos = tgt;
      end
      if (n == 0 && !store) begin
         push(1, 1, 0, 1, 9, 1);                        // R9 immediate finish
      end else begin
         push(0, 1, 1, 0, 4, L_SU);                     // R4 setup
         for (int i = 1; i <= n; i++) begin
            push(0, 0, 1, 0, 5, T_LOW);                 // R5 low phase
            if (i < n || store) push(0, 1, 1, 0, 5, T_HIGH);
         end
         tr = store ? 6 : 7;                            // R6 keep / R7 volatile
         push(0, store, 1, 0, tr, T_END);
         push(1, store, 1, 0, tr, 1);
         push(1, 1, 1, 0, 8, T_DESEL);                  // R8 hold-off
         push(1, 1, 0, 1, 12, 1);                       // R12 done pulse
      end
      txn_open   = 1'b1;
      txn_store  = store;
      pulses     = 0;
      exp_pulses = n;
      txn_req    = req;
      cyc();
      cmd_valid = 1'b0;
   endtask

   task automatic drain();
      while (q.size() > 0) cyc();
      repeat (3) cyc();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(1, "reset sel_n", 32'(sel_n), 32'd1);
      chk(1, "reset step_n", 32'(step_n), 32'd1);
      chk(1, "reset busy", 32'(busy), 32'd0);
      chk(1, "reset done", 32'(done), 32'd0);
      chk(1, "reset ready", 32'(cmd_ready), 32'd1);
      chk(1, "reset pos", 32'(pos_out), 32'd0);
      repeat (2) cyc();

      send(0, 1'b0, 1'b1, 10);    // R10 calibrate from unknown tap 17, volatile
      send(9, 1'b1, 1'b0, 3);     // R3 up, keep (R6); sent while busy (R2)
      send(3, 1'b0, 1'b0, 3);     // R3 down, volatile (R7)
      drain();
      chk(7, "volatile left storage", 32'(nv), 32'd9);
      send(3, 1'b1, 1'b0, 9);     // R9 zero steps, keep
      drain();
      send(3, 1'b0, 1'b0, 9);     // R9 zero steps, nothing on the pins
      drain();
      send(31, 1'b1, 1'b0, 3);    // R3 to the top tap
      send(5, 1'b1, 1'b1, 10);    // R10 calibrate ignores target, keep; queued while busy (R2)
      send(20, 1'b0, 1'b0, 11);   // R11 tracked tap follows
      drain();
      chk(10, "device at target", 32'(wiper), 32'd20);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL R2 watchdog: actual running expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule